// File: doc/BRIEF.md
# Cascadable Reload Down-Counter Timer Pair

This block holds a set of down-counting timers, two by default. Each has its own reload value, control word and count readback. Each timer counts down from its programmed reload value. It raises a level interrupt when the count lands on zero. The interrupt stays high until the reload value is copied into the counter again. That copy comes either from automatic reload or from a software load strobe. A timer can be told to count the zero events of the timer just below it instead of clock cycles. Two timers chained this way act as one longer timer.

Software reaches the block through a single-cycle write port and a combinational read port. Address bits above the low two select the timer. The low two bits select a register inside that timer. Timers that do not select cascading run fully independently of each other.

Top module: `tmr_cascade_top`

## Requirements
- R1: After reset every count, reload value, control bit and interrupt reads as zero.
- R2: Writing the control register (select 0) with bit 2 set copies the timer's stored reload value into its count on that clock edge and drives its interrupt low. Bit 2 is a strobe: it always reads back as 0.
- R3: With control bit 0 (run) set and cascading off, a nonzero count drops by one every clock. With the run bit clear, the count holds.
- R4: A timer's interrupt rises on the same clock edge at which its count steps from 1 to 0, and at no other moment.
- R5: With control bit 1 (auto-reload) clear, a count that reached zero stays at zero and the interrupt stays high until a load strobe.
- R6: With auto-reload and run set, the clock after the count reads zero reloads the counter and lowers the interrupt. For reload value N the period is N+1 clocks, and the interrupt is high for exactly one of them.
- R7: Writing the reload register (select 1) does not change the running count. The new value takes effect at the next reload.
- R8: The count register (select 2) is read-only. Writes to it leave the count unchanged.
- R9: For timer k>0, control bit 3 (cascade) makes the count drop once per zero event of timer k-1 and hold on all other clocks. Timer 0 has no cascade source, so its bit 3 reads 0 and has no effect.
- R10: Without cascading, a timer's count and interrupt do not depend on any other timer's activity.
- R11: The address is {timer index, select}. Select 3 reads zero. Read data shows the addressed register combinationally. Control reads as {bit3 cascade, bit2 0, bit1 auto-reload, bit0 run}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | {timer index, register select} |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the addressed register |
| irq_o | output | 2 | Level interrupt, one bit per timer |

## Verification
The assertions assume inputs with known values, and a reset held low before the first checked edge. They also assume every timer index in the address space exists, which holds when the number of timers is a power of two. The random stimulus only drives defined values. It keeps reload values below a dozen, so that zero events, reloads and cascaded decrements happen often. Writes fall on about one clock in eight, which leaves long stretches of free counting between them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_AUTO_BIT = 1;
   localparam int CTRL_LOAD_BIT = 2;
   localparam int CTRL_CASC_BIT = 3;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_COUNT  = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic casc;
      logic auto_rl;
      logic run;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter bit HAS_CASC = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ctrl_we_i,
   input  logic             reload_we_i,
   input  logic [CNT_W-1:0] wdata_i,
   output tmr_ctrl_t        ctrl_o,
   output logic [CNT_W-1:0] reload_o,
   output logic             load_o
);
   logic run_q, auto_q, casc_q;
   logic [CNT_W-1:0] reload_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q    <= 1'b0;
         auto_q   <= 1'b0;
         reload_q <= '0;
      end else begin
         if (ctrl_we_i) begin
            run_q  <= wdata_i[CTRL_RUN_BIT];
            auto_q <= wdata_i[CTRL_AUTO_BIT];
         end
         if (reload_we_i) reload_q <= wdata_i;
      end
   end

   generate
      if (HAS_CASC) begin : g_casc
         always_ff @(posedge clk_i) begin
            if (!rst_ni)        casc_q <= 1'b0;
            else if (ctrl_we_i) casc_q <= wdata_i[CTRL_CASC_BIT];
         end
      end else begin : g_no_casc
         assign casc_q = 1'b0;
      end
   endgenerate

   always_comb begin
      ctrl_o.run     = run_q;
      ctrl_o.auto_rl = auto_q;
      ctrl_o.casc    = casc_q;
   end

   assign reload_o = reload_q;
   assign load_o   = ctrl_we_i & wdata_i[CTRL_LOAD_BIT];
endmodule

// File: rtl/tmr_chan_core.sv
module tmr_chan_core
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  tmr_ctrl_t        ctrl_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             load_i,
   input  logic             casc_evt_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             irq_o,
   output logic             zero_evt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic irq_q, zev_q, tick;

   always_comb tick = ctrl_i.run & (ctrl_i.casc ? casc_evt_i : 1'b1);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
         zev_q <= 1'b0;
      end else begin
         zev_q <= 1'b0;
         if (load_i) begin
            cnt_q <= reload_i;
            irq_q <= 1'b0;
         end else if (cnt_q != '0 && tick) begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) begin
               irq_q <= 1'b1;
               zev_q <= 1'b1;
            end
         end else if (cnt_q == '0 && ctrl_i.run && ctrl_i.auto_rl) begin
            cnt_q <= reload_i;
            irq_q <= 1'b0;
         end
      end
   end

   assign cnt_o      = cnt_q;
   assign irq_o      = irq_q;
   assign zero_evt_o = zev_q;

   // R4
   irq_rise_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_q) |-> cnt_q == '0);
   // R2
   load_clears_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (!irq_q && cnt_q == $past(reload_i)));
   // R6
   auto_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_q && ctrl_i.run && ctrl_i.auto_rl && !load_i) |=> !irq_q);
   // R5
   hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == '0 && irq_q && !ctrl_i.auto_rl && !load_i) |=> (cnt_q == '0 && irq_q));
   // R3
   no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && cnt_q != '0) |=> cnt_q <= $past(cnt_q));
   // R9
   casc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_i.casc && !casc_evt_i && !load_i && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_cascade_top.sv
module tmr_cascade_top
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int NUM_TMR = 2,
   localparam int TW     = $clog2(NUM_TMR),
   localparam int AW     = TW + 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic [AW-1:0]      addr_i,
   input  logic [CNT_W-1:0]   wr_data_i,
   output logic [CNT_W-1:0]   rd_data_o,
   output logic [NUM_TMR-1:0] irq_o
);
   localparam int SLOTS = 1 << TW;

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("tmr_cascade_top: CNT_W must be at least 4");
      end
      if (NUM_TMR < 2 || NUM_TMR > 16) begin : g_bad_count
         $error("tmr_cascade_top: NUM_TMR must lie in 2..16");
      end
   endgenerate

   logic [TW-1:0] idx;
   reg_sel_e      sel;
   assign idx = addr_i[AW-1:2];
   assign sel = reg_sel_e'(addr_i[1:0]);

   tmr_ctrl_t        ctrl_a [NUM_TMR];
   logic [CNT_W-1:0] rel_a  [NUM_TMR];
   logic [CNT_W-1:0] cnt_a  [NUM_TMR];
   logic             load_a [NUM_TMR];
   logic             zev_a  [NUM_TMR];
   logic             evt_a  [NUM_TMR];

   genvar k;
   generate
      for (k = 0; k < NUM_TMR; k++) begin : g_tmr
         logic hit;
         assign hit = wr_en_i && (idx == TW'(k));

         if (k == 0) begin : g_src_none
            assign evt_a[k] = 1'b0;
         end else begin : g_src_prev
            assign evt_a[k] = zev_a[k-1];
         end

         tmr_chan_regs #(
            .CNT_W    (CNT_W),
            .HAS_CASC (k > 0)
         ) u_regs (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .ctrl_we_i   (hit && sel == SEL_CTRL),
            .reload_we_i (hit && sel == SEL_RELOAD),
            .wdata_i     (wr_data_i),
            .ctrl_o      (ctrl_a[k]),
            .reload_o    (rel_a[k]),
            .load_o      (load_a[k])
         );

         tmr_chan_core #(
            .CNT_W (CNT_W)
         ) u_core (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ctrl_i     (ctrl_a[k]),
            .reload_i   (rel_a[k]),
            .load_i     (load_a[k]),
            .casc_evt_i (evt_a[k]),
            .cnt_o      (cnt_a[k]),
            .irq_o      (irq_o[k]),
            .zero_evt_o (zev_a[k])
         );
      end
   endgenerate

   logic [CNT_W-1:0] slot_ctrl [SLOTS];
   logic [CNT_W-1:0] slot_rel  [SLOTS];
   logic [CNT_W-1:0] slot_cnt  [SLOTS];

   genvar s;
   generate
      for (s = 0; s < SLOTS; s++) begin : g_slot
         if (s < NUM_TMR) begin : g_live
            assign slot_ctrl[s] = CNT_W'({ctrl_a[s].casc, 1'b0,
                                          ctrl_a[s].auto_rl, ctrl_a[s].run});
            assign slot_rel[s]  = rel_a[s];
            assign slot_cnt[s]  = cnt_a[s];
         end else begin : g_empty
            assign slot_ctrl[s] = '0;
            assign slot_rel[s]  = '0;
            assign slot_cnt[s]  = '0;
         end
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_CTRL:   rd_data_o = slot_ctrl[idx];
         SEL_RELOAD: rd_data_o = slot_rel[idx];
         SEL_COUNT:  rd_data_o = slot_cnt[idx];
         default:    rd_data_o = '0;
      endcase
   end
endmodule

// File: tb/tmr_cascade_top_tb.sv
`timescale 1ns/1ps
module tmr_cascade_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [2:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rd_data;
   logic [1:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   tmr_cascade_top dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .addr_i    (addr),
      .wr_data_i (wdata),
      .rd_data_o (rd_data),
      .irq_o     (irq)
   );

   logic [31:0] m_cnt [2];
   logic [31:0] m_rel [2];
   logic        m_run [2], m_auto [2], m_casc [2], m_irq [2], m_zp [2];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_step(input logic wr, input logic [2:0] a, input logic [31:0] d);
      logic ozp [2];
      for (int k = 0; k < 2; k++) ozp[k] = m_zp[k];
      for (int k = 0; k < 2; k++) begin
         logic ld, tick;
         ld   = wr && (a[2] == k[0]) && (a[1:0] == 2'd0) && d[2];
         tick = m_run[k] && ((k > 0 && m_casc[k]) ? ozp[(k == 0) ? 0 : k-1] : 1'b1);
         m_zp[k] = 1'b0;
         if (ld) begin
            m_cnt[k] = m_rel[k];
            m_irq[k] = 1'b0;
         end else if (m_cnt[k] != 0 && tick) begin
            if (m_cnt[k] == 1) begin
               m_irq[k] = 1'b1;
               m_zp[k]  = 1'b1;
            end
            m_cnt[k] = m_cnt[k] - 1;
         end else if (m_cnt[k] == 0 && m_run[k] && m_auto[k]) begin
            m_cnt[k] = m_rel[k];
            m_irq[k] = 1'b0;
         end
      end
      if (wr) begin
         int t = a[2];
         if (a[1:0] == 2'd0) begin
            m_run[t]  = d[0];
            m_auto[t] = d[1];
            m_casc[t] = (t == 1) ? d[3] : 1'b0;
         end else if (a[1:0] == 2'd1) begin
            m_rel[t] = d;
         end
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [2:0] a);
      int t = a[2];
      case (a[1:0])
         2'd0:    return {28'd0, m_casc[t], 1'b0, m_auto[t], m_run[t]};
         2'd1:    return m_rel[t];
         2'd2:    return m_cnt[t];
         default: return 32'd0;
      endcase
   endfunction

   task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = wr;
      addr  = a;
      wdata = d;
      model_step(wr, a, d);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic check_all(input string tag);
      chk(tag, rd_data, exp_read(addr));
      chk("R4 interrupt vector", {30'd0, irq}, {30'd0, m_irq[1], m_irq[0]});
   endtask

   task automatic finish_sim();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_sim();
   end

   initial begin
      int highs;
      logic [31:0] v;
      void'($urandom(32'd4711));
      for (int k = 0; k < 2; k++) begin
         m_cnt[k] = 0; m_rel[k] = 0; m_run[k] = 0; m_auto[k] = 0;
         m_casc[k] = 0; m_irq[k] = 0; m_zp[k] = 0;
      end
      rst_n = 1'b0; wr_en = 1'b0; addr = 3'd0; wdata = 32'd0;
      repeat (3) @(posedge clk);
      // R1: reset state across every address
      for (int a = 0; a < 8; a++) begin
         addr = 3'(a);
         #1;
         chk("R1 reset read", rd_data, 32'd0);
      end
      chk("R1 reset irq", {30'd0, irq}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5: one-shot mode holds zero and interrupt
      step(1'b1, 3'b001, 32'd2);      check_all("R7 reload write");
      step(1'b1, 3'b000, 32'd1);      check_all("R3 run bit");
      step(1'b1, 3'b000, 32'd5);      check_all("R2 load");
      for (int i = 0; i < 10; i++) begin
         step(1'b0, 3'b010, 32'd0);
         check_all("R3 count down");
      end
      chk("R5 count held at zero", rd_data, 32'd0);
      chk("R5 irq held", {31'd0, irq[0]}, 32'd1);
      step(1'b1, 3'b000, 32'd5);
      chk("R2 load bit reads 0", rd_data, 32'd1);
      chk("R2 irq cleared by load", {31'd0, irq[0]}, 32'd0);
      step(1'b0, 3'b010, 32'd0);
      chk("R2 count after load", rd_data, 32'd1);
      step(1'b1, 3'b000, 32'd0);      check_all("R3 stop");

      // R6: periodic mode, reload 3 -> period 4, one-clock pulse
      step(1'b1, 3'b001, 32'd3);      check_all("R6 reload");
      step(1'b1, 3'b000, 32'd7);      check_all("R6 start");
      highs = 0;
      for (int i = 0; i < 12; i++) begin
         step(1'b0, 3'b010, 32'd0);
         check_all("R6 periodic");
         highs += int'(irq[0]);
      end
      chk("R6 pulse count in 12 clocks", 32'(highs), 32'd3);
      step(1'b1, 3'b000, 32'd0);

      // R8: count register is read-only
      step(1'b0, 3'b010, 32'd0);
      v = rd_data;
      step(1'b1, 3'b010, 32'hDEAD_BEEF);
      chk("R8 count write ignored", rd_data, v);

      // R11: select 3 reads zero
      step(1'b0, 3'b011, 32'd0);
      chk("R11 empty select", rd_data, 32'd0);
      step(1'b0, 3'b111, 32'd0);
      chk("R11 empty select t1", rd_data, 32'd0);

      // R9: cascade
      step(1'b1, 3'b000, 32'd8);
      chk("R9 timer0 cascade bit reads 0", rd_data, 32'd0);
      step(1'b1, 3'b001, 32'd1);      check_all("R9 setup");
      step(1'b1, 3'b101, 32'd4);      check_all("R9 setup");
      step(1'b1, 3'b100, 32'hD);      check_all("R9 cascade ctrl");
      step(1'b1, 3'b000, 32'd7);      check_all("R9 source start");
      for (int i = 0; i < 20; i++) begin
         step(1'b0, 3'b110, 32'd0);
         check_all("R9 cascaded count");
      end
      step(1'b1, 3'b000, 32'd0);
      step(1'b1, 3'b100, 32'hD);
      for (int i = 0; i < 10; i++) step(1'b0, 3'b110, 32'd0);
      chk("R9 hold without source events", rd_data, 32'd4);

      // R10: independent timers
      step(1'b1, 3'b101, 32'd6);
      step(1'b1, 3'b100, 32'd7);      check_all("R10 t1 start");
      step(1'b1, 3'b001, 32'd2);
      step(1'b1, 3'b000, 32'd7);      check_all("R10 t0 start");
      for (int i = 0; i < 15; i++) begin
         step(1'b0, 3'b110, 32'd0);
         check_all("R10 independent count");
      end
      // R7: reload change mid-count
      step(1'b1, 3'b101, 32'd9);
      for (int i = 0; i < 12; i++) begin
         step(1'b0, 3'b110, 32'd0);
         check_all("R7 new reload deferred");
      end

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic w;
         logic [2:0] a;
         logic [31:0] d;
         w = ($urandom % 8) == 0;
         a = 3'($urandom % 8);
         case (a[1:0])
            2'd0:    d = $urandom % 16;
            2'd1:    d = $urandom % 12;
            default: d = $urandom;
         endcase
         step(w, a, d);
         case (a[1:0])
            2'd0:    check_all("R2 ctrl readback");
            2'd1:    check_all("R7 reload readback");
            2'd2:    check_all("R3 count readback");
            default: check_all("R11 empty readback");
         endcase
      end
      finish_sim();
   end
endmodule